// File: doc/BRIEF.md
# Lockable SMRAM Window Register

This block is a single byte-wide configuration register that a host agent uses to discover, enable and then permanently seal a protected memory window. The window has a fixed base address (default 0x30000) and a parameterized size (default 128 KB).

The register is driven through a handshake:

- Before discovery, the register ignores every value except the arming code 0xFF.
- After arming, it reads back a "capability present" value.
- A follow-up lock code seals the register. After that, no write to it has any effect until the next system reset.

While the register is sealed, the block sits on the byte-wide memory path. It blocks non-privileged accesses that fall inside the window: reads return all ones and writes never reach RAM. Accesses made while the privileged-mode input is high pass through, as do accesses outside the window.

The `LEGACY` parameter builds a different variant. In that variant the register is an ordinary read/write byte and the memory path is never blocked. The RAM array itself is outside the block. The memory path is combinational, so an access is forwarded or blocked in the same cycle it is presented.

Top module: `smram_win_lock`

## Requirements
- R1: After reset the register reads 0x00 at configuration offset 0x9C, and memory accesses to the window are forwarded to RAM, with read data taken from RAM.
- R2: In the idle state (reads 0x00), a write of any value other than 0xFF to offset 0x9C leaves the register reading 0x00.
- R3: In the idle state, a write of 0xFF to offset 0x9C makes the register read 0x01 from the next cycle on.
- R4: In the offered state (reads 0x01), a write of 0x02 makes it read 0x02 (sealed) from the next cycle on. Any other written value leaves it reading 0x01.
- R5: Once sealed, every written value 0x00 to 0xFF is ignored and the register keeps reading 0x02 until reset.
- R6: While sealed, a memory access with smm_active low and an address in [BASE, BASE+WIN_BYTES) is not forwarded (ram_req low). A read of that kind returns 0xFF, and a write of that kind changes no RAM content.
- R7: While sealed, accesses with smm_active high, and accesses outside the window, are forwarded unchanged and return RAM data.
- R8: A reset returns the register to 0x00 and restores forwarding of window accesses. RAM content written before the seal, or by privileged accesses, is still visible afterwards.
- R9: Configuration writes to any offset other than 0x9C do not change the register. Reads at other offsets return 0x00.
- R10: With LEGACY=1, the register reads back the last byte written to offset 0x9C (0x00 after reset), and every memory access is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| smm_active | input | 1 | High when the requester runs in privileged management mode |
| mem_req | input | 1 | Memory access request from the requester |
| mem_we | input | 1 | Memory access is a write |
| mem_addr | input | ADDR_W | Memory byte address |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Memory read data returned to the requester |
| ram_req | output | 1 | Access forwarded to RAM |
| ram_we | output | 1 | Forwarded access is a write |
| ram_addr | output | ADDR_W | Forwarded address |
| ram_wdata | output | 8 | Forwarded write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
Every one of the 255 non-arming values is written in the idle state. A design that armed on a partial match, such as a single set bit, would read 0x01 early. Stray codes, including a repeated 0xFF, are written in the offered state; a design that re-armed or accepted any nonzero value would seal or drift. After the seal, all 256 values are replayed while the first and last window bytes are hammered. A leaky seal or an off-by-one window edge would show up as forwarded data. Privileged accesses, the bytes just outside both window edges, a reset after sealing (data must survive), and a legacy instance beside the main one catch designs that block too much or forget to clear the seal.

// File: rtl/smram_win_lock_pkg.sv
package smram_win_lock_pkg;

   typedef enum logic [1:0] {
      WL_IDLE    = 2'd0,
      WL_OFFERED = 2'd1,
      WL_SEALED  = 2'd2
   } wl_state_e;

   localparam logic [7:0] WL_ARM_CODE   = 8'hFF;
   localparam logic [7:0] WL_SEAL_CODE  = 8'h02;
   localparam logic [7:0] WL_RD_IDLE    = 8'h00;
   localparam logic [7:0] WL_RD_OFFERED = 8'h01;
   localparam logic [7:0] WL_RD_SEALED  = 8'h02;
   localparam logic [7:0] WL_BLOCK_DATA = 8'hFF;

endpackage

// File: rtl/smram_win_fsm.sv
module smram_win_fsm
   import smram_win_lock_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit,
   input  logic [7:0] wdata,
   output logic [7:0] reg_val,
   output logic       sealed
);

   wl_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WL_IDLE;
      end else if (wr_hit) begin
         case (state_q)
            WL_IDLE:    if (wdata == WL_ARM_CODE)  state_q <= WL_OFFERED;
            WL_OFFERED: if (wdata == WL_SEAL_CODE) state_q <= WL_SEALED;
            default:    state_q <= state_q;
         endcase
      end
   end

   always_comb begin
      case (state_q)
         WL_OFFERED: reg_val = WL_RD_OFFERED;
         WL_SEALED:  reg_val = WL_RD_SEALED;
         default:    reg_val = WL_RD_IDLE;
      endcase
   end

   assign sealed = (state_q == WL_SEALED);

endmodule

// File: rtl/smram_win_plain.sv
module smram_win_plain (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit,
   input  logic [7:0] wdata,
   output logic [7:0] reg_val
);

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_val <= 8'h00;
      else if (wr_hit) reg_val <= wdata;
   end

endmodule

// File: rtl/smram_win_gate.sv
module smram_win_gate
   import smram_win_lock_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned BASE      = 32'h0003_0000,
   parameter int unsigned WIN_BYTES = 32'h0002_0000
) (
   input  logic              sealed,
   input  logic              smm_active,
   input  logic              mem_req,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_wdata,
   output logic [7:0]        mem_rdata,
   output logic              ram_req,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata
);

   localparam logic [ADDR_W:0] LO_A = (ADDR_W+1)'(BASE);
   localparam logic [ADDR_W:0] HI_A = (ADDR_W+1)'(BASE + WIN_BYTES);

   logic in_win;
   logic block;

   assign in_win    = ({1'b0, mem_addr} >= LO_A) && ({1'b0, mem_addr} < HI_A);
   assign block     = sealed && !smm_active && in_win;

   assign ram_req   = mem_req && !block;
   assign ram_we    = mem_we && !block;
   assign ram_addr  = mem_addr;
   assign ram_wdata = mem_wdata;
   assign mem_rdata = block ? WL_BLOCK_DATA : ram_rdata;

endmodule

// File: rtl/smram_win_lock.sv
module smram_win_lock
   import smram_win_lock_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned BASE       = 32'h0003_0000,
   parameter int unsigned WIN_BYTES  = 32'h0002_0000,
   parameter logic [7:0]  CFG_OFFSET = 8'h9C,
   parameter bit          LEGACY     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        cfg_addr,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              smm_active,
   input  logic              mem_req,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_wdata,
   output logic [7:0]        mem_rdata,
   output logic              ram_req,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata
);

   localparam longint unsigned SPAN = longint'(1) << ADDR_W;

   if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_width
      $error("smram_win_lock: ADDR_W out of range");
   end
   if (WIN_BYTES == 0) begin : g_bad_win
      $error("smram_win_lock: WIN_BYTES must be nonzero");
   end
   if (longint'(BASE) + longint'(WIN_BYTES) > SPAN) begin : g_bad_span
      $error("smram_win_lock: window exceeds address space");
   end

   logic       cfg_hit;
   logic       wr_hit;
   logic [7:0] reg_val;
   logic       sealed_w;

   assign cfg_hit = (cfg_addr == CFG_OFFSET);
   assign wr_hit  = cfg_wr && cfg_hit;

   if (LEGACY) begin : g_legacy
      smram_win_plain u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (wr_hit),
         .wdata   (cfg_wdata),
         .reg_val (reg_val)
      );
      assign sealed_w = 1'b0;
   end else begin : g_handshake
      smram_win_fsm u_fsm (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_hit  (wr_hit),
         .wdata   (cfg_wdata),
         .reg_val (reg_val),
         .sealed  (sealed_w)
      );
   end

   assign cfg_rdata = cfg_hit ? reg_val : 8'h00;

   smram_win_gate #(
      .ADDR_W    (ADDR_W),
      .BASE      (BASE),
      .WIN_BYTES (WIN_BYTES)
   ) u_gate (
      .sealed     (sealed_w),
      .smm_active (smm_active),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .ram_req    (ram_req),
      .ram_we     (ram_we),
      .ram_addr   (ram_addr),
      .ram_wdata  (ram_wdata),
      .ram_rdata  (ram_rdata)
   );

endmodule

// File: rtl/smram_win_lock_chk.sv
module smram_win_lock_chk #(
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned BASE       = 32'h0003_0000,
   parameter int unsigned WIN_BYTES  = 32'h0002_0000,
   parameter logic [7:0]  CFG_OFFSET = 8'h9C,
   parameter bit          LEGACY     = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        cfg_addr,
   input logic              cfg_wr,
   input logic [7:0]        cfg_wdata,
   input logic [7:0]        reg_val,
   input logic              sealed_w,
   input logic              smm_active,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_rdata,
   input logic              ram_req,
   input logic [ADDR_W-1:0] ram_addr
);

   logic hit_wr;
   logic in_win;
   assign hit_wr = cfg_wr && (cfg_addr == CFG_OFFSET);
   assign in_win = (longint'(mem_addr) >= longint'(BASE)) &&
                   (longint'(mem_addr) < longint'(BASE) + longint'(WIN_BYTES));

   // R7: privileged or out-of-window accesses always reach RAM at the same address
   p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && (smm_active || !in_win)) |-> (ram_req && ram_addr == mem_addr));

   if (LEGACY) begin : g_leg_chk
      // R10: plain byte reads back what was written
      p_legacy_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
         hit_wr |=> (reg_val == $past(cfg_wdata)));
      // R10: no access is ever withheld
      p_legacy_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
         mem_req |-> ram_req);
   end else begin : g_hs_chk
      // R2: non-arming writes in idle keep it idle
      p_idle_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_wr && reg_val == 8'h00 && cfg_wdata != 8'hFF) |=> (reg_val == 8'h00));
      // R3: arming code in idle offers the capability
      p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_wr && reg_val == 8'h00 && cfg_wdata == 8'hFF) |=> (reg_val == 8'h01));
      // R5: seal is sticky until reset
      p_seal_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
         sealed_w |=> (sealed_w && reg_val == 8'h02));
      // R6: sealed, unprivileged, in-window access is withheld and reads all ones
      p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (sealed_w && mem_req && !smm_active && in_win) |-> (!ram_req && mem_rdata == 8'hFF));
   end

endmodule

bind smram_win_lock smram_win_lock_chk #(
   .ADDR_W     (ADDR_W),
   .BASE       (BASE),
   .WIN_BYTES  (WIN_BYTES),
   .CFG_OFFSET (CFG_OFFSET),
   .LEGACY     (LEGACY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_addr   (cfg_addr),
   .cfg_wr     (cfg_wr),
   .cfg_wdata  (cfg_wdata),
   .reg_val    (reg_val),
   .sealed_w   (sealed_w),
   .smm_active (smm_active),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rdata  (mem_rdata),
   .ram_req    (ram_req),
   .ram_addr   (ram_addr)
);

// File: tb/smram_win_lock_tb.sv
module smram_win_lock_tb;

   localparam int AW      = 20;
   localparam int W_LO    = 'h30000;
   localparam int W_HI    = 'h50000;
   localparam logic [7:0] OFF = 8'h9C;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic [7:0]    cfg_addr, cfg_wdata;
   logic          cfg_wr, smm_active, mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    cfg_rdata, mem_rdata, ram_wdata, ram_rdata;
   logic          ram_req, ram_we;
   logic [AW-1:0] ram_addr;

   logic [7:0]    l_cfg_rdata, l_mem_rdata, l_ram_wdata;
   logic          l_ram_req, l_ram_we;
   logic [AW-1:0] l_ram_addr;

   smram_win_lock u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smm_active(smm_active),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ram_req(ram_req),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata));

   smram_win_lock #(.LEGACY(1'b1)) u_dut_legacy (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(l_cfg_rdata), .smm_active(smm_active),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(l_mem_rdata), .ram_req(l_ram_req),
      .ram_we(l_ram_we), .ram_addr(l_ram_addr), .ram_wdata(l_ram_wdata),
      .ram_rdata(8'h5A));

   // behavioural RAM behind the main instance (test addresses map to distinct slots)
   logic [7:0] ram_mem [0:15];
   function automatic int slot(input logic [AW-1:0] a);
      return int'({a[17:16], a[1:0]});
   endfunction
   initial for (int k = 0; k < 16; k++) ram_mem[k] = 8'h00;
   always_ff @(posedge clk) if (ram_req && ram_we) ram_mem[slot(ram_addr)] <= ram_wdata;
   assign ram_rdata = ram_mem[slot(ram_addr)];

   // reference model
   int         m_state;
   logic [7:0] m_leg;
   logic [7:0] m_ram [int];
   int         checks = 0, failures = 0;
   string      cur_req = "R1";
   bit         done = 1'b0;

   function automatic bit m_block();
      return (m_state == 2) && !smm_active && int'(mem_addr) >= W_LO && int'(mem_addr) < W_HI;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      int e_cfg;
      int e_rd;
      e_cfg = (cfg_addr != OFF) ? 0 : (m_state == 0 ? 0 : (m_state == 1 ? 1 : 2));
      chk(cur_req, "cfg_rdata", int'(cfg_rdata), e_cfg);
      chk("R10", "legacy cfg_rdata", int'(l_cfg_rdata), (cfg_addr == OFF) ? int'(m_leg) : 0);
      if (mem_req) begin
         chk(cur_req, "ram_req", int'(ram_req), m_block() ? 0 : 1);
         chk("R10", "legacy ram_req", int'(l_ram_req), 1);
         if (!mem_we) begin
            e_rd = m_block() ? 'hFF
                 : (m_ram.exists(int'(mem_addr)) ? int'(m_ram[int'(mem_addr)]) : 0);
            chk(cur_req, "mem_rdata", int'(mem_rdata), e_rd);
            chk("R10", "legacy mem_rdata", int'(l_mem_rdata), 'h5A);
         end
      end
   endtask

   task automatic model_step();
      if (!rst_n) begin
         m_state = 0;
         m_leg   = 8'h00;
      end else begin
         if (mem_req && mem_we && !m_block()) m_ram[int'(mem_addr)] = mem_wdata;
         if (cfg_wr && cfg_addr == OFF) begin
            m_leg = cfg_wdata;
            if (m_state == 0 && cfg_wdata == 8'hFF) m_state = 1;
            else if (m_state == 1 && cfg_wdata == 8'h02) m_state = 2;
         end
      end
   endtask

   task automatic cyc();
      #2;
      if (rst_n) compare();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic [7:0] v, input logic [7:0] off);
      cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = v;
      cyc();
      cfg_wr = 1'b0; cfg_addr = OFF;
      cyc();
   endtask

   task automatic mem_op(input bit we, input int a, input logic [7:0] d, input bit smm);
      mem_req = 1'b1; mem_we = we; mem_addr = AW'(a); mem_wdata = d; smm_active = smm;
      cyc();
      mem_req = 1'b0; mem_we = 1'b0; smm_active = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc(); cyc();
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; cfg_addr = OFF; cfg_wr = 1'b0; cfg_wdata = 8'h00;
      smm_active = 1'b0; mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = 8'h00;
      m_state = 0; m_leg = 8'h00;
      @(negedge clk);
      do_reset();

      // R1: reset state and open window
      cur_req = "R1";
      cyc();
      mem_op(1'b1, W_LO, 8'h32, 1'b0);
      mem_op(1'b0, W_LO, 8'h00, 1'b0);

      // R2: every non-arming value ignored in idle
      cur_req = "R2";
      for (int i = 0; i < 255; i++) cfg_write(8'(i), OFF);

      // R9: arming code at a wrong offset is ignored
      cur_req = "R9";
      cfg_write(8'hFF, 8'h9D);
      cfg_write(8'hFF, 8'h1C);
      cyc();

      // R3: arming
      cur_req = "R3";
      cfg_write(8'hFF, OFF);

      // R4: stray codes in offered state, then seal
      cur_req = "R4";
      cfg_write(8'h00, OFF);
      cfg_write(8'hFF, OFF);
      cfg_write(8'h03, OFF);
      cfg_write(8'h01, OFF);
      cfg_write(8'h02, OFF);

      // R5 and R6: sealed register immune, window blocked at both edges
      for (int i = 0; i <= 255; i++) begin
         cur_req = "R5";
         cfg_write(8'(i), OFF);
         cur_req = "R6";
         mem_op(1'b1, W_LO, 8'h77, 1'b0);
         mem_op(1'b0, W_LO, 8'h00, 1'b0);
         mem_op(1'b1, W_HI - 1, 8'h66, 1'b0);
         mem_op(1'b0, W_HI - 1, 8'h00, 1'b0);
      end

      // R7: privileged and out-of-window accesses pass while sealed
      cur_req = "R7";
      mem_op(1'b0, W_LO, 8'h00, 1'b1);
      mem_op(1'b1, W_LO, 8'h44, 1'b1);
      mem_op(1'b0, W_LO, 8'h00, 1'b1);
      mem_op(1'b1, W_LO - 1, 8'h11, 1'b0);
      mem_op(1'b0, W_LO - 1, 8'h00, 1'b0);
      mem_op(1'b1, W_HI, 8'h22, 1'b0);
      mem_op(1'b0, W_HI, 8'h00, 1'b0);
      mem_op(1'b0, W_LO, 8'h00, 1'b0);

      // R8: reset reopens the window, data retained
      cur_req = "R8";
      do_reset();
      cyc();
      mem_op(1'b0, W_LO, 8'h00, 1'b0);
      mem_op(1'b1, W_LO, 8'h23, 1'b0);
      mem_op(1'b0, W_LO, 8'h00, 1'b0);
      cfg_write(8'h05, OFF);
      cfg_write(8'hFF, OFF);

      // R10: legacy echo of every value (compared each cycle)
      cur_req = "R8";
      for (int i = 0; i <= 255; i++) cfg_write(8'(255 - i), OFF);

      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete");
         finish_run();
      end
   end

endmodule